// File: doc/BRIEF.md
# Paged serial management register file

This block is the slave end of a two-wire serial management link. One wire is the management clock. The other is a data line shared by the master and the slave. The block watches the link for read and write frames addressed to its own device ID. It serves sixteen-bit registers behind a five-bit register address.

There are 128 registers of 16 bits, split into four pages of 32. One register address is reserved in every page as a page selector. Writing it changes which page the other 31 addresses reach. This lets the full set sit behind the short address field of the frame.

Both link wires are oversampled by the system clock. The data line is read on rising management-clock edges. Read data is put on the line after falling edges, so it is stable at the next rising edge. The data line is shown as separate value and output-enable ports, and the tri-state pad sits outside the block.

Top module: `smi_paged_regfile`

## Requirements
- R1: After reset the data output enable is low, page 0 is active, and every register reads as zero.
- R2: A frame is accepted only if at least 32 consecutive ones come before the start code 0 then 1. A frame with a shorter preamble changes no register and never drives the line.
- R3: A frame is abandoned if the start code is not 0 then 1, or if the opcode is anything other than 1,0 (read) or 0,1 (write). The block then hunts for a fresh preamble, and the next well-formed frame is served.
- R4: On a read, the line stays undriven during the first turnaround bit. The slave drives 0 for the second turnaround bit, then drives 16 data bits MSB first. The line is released at the first falling edge after the last data bit.
- R5: On a write, the 16 data bits that follow the turnaround are taken MSB first. They are stored when the last bit is sampled. The turnaround bits sent by the master are not checked.
- R6: A frame whose 5-bit device address differs from local_id_i changes no register and never enables the output.
- R7: Register address 31 is the page selector in every page. A write to it sets the page to data bits [1:0]. A read from it returns the page in bits [1:0], with all other bits zero.
- R8: Every other address reaches entry page*32+address. The pages are independent, so a write in one page is not visible in another.
- R9: A new preamble is counted from the bit right after the last data bit. A second frame with exactly 32 preamble ones, sent with no idle gap, is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, used to oversample the link |
| rst_ni | input | 1 | Active-low asynchronous reset |
| local_id_i | input | 5 | Device address this block answers to |
| mgmt_clk_i | input | 1 | Management clock from the master |
| mgmt_data_i | input | 1 | Resolved level of the shared data line |
| mgmt_data_o | output | 1 | Value the slave drives on the data line |
| mgmt_data_oe_o | output | 1 | Enable for the data-line driver |

## Verification
Two things fall on the same sampling edge: storing a write word, and restarting the preamble count. The edge that takes the last data bit both commits the word and must count the very next 1 as preamble. The bench provokes this with a write followed at once by a read of the same register, using exactly 32 ones and no idle gap. It judges the result by whether the read is served and returns the written word. The same overlap is also checked for the page selector: a read issued straight after a page write must already use the new page. The bench also runs seeded random frames against a model of the bank and the page.

// File: rtl/smi_pkg.sv
package smi_pkg;
  typedef enum logic [2:0] {
    S_PRE,
    S_ST1,
    S_OP,
    S_DEV,
    S_REG,
    S_TA,
    S_DATA
  } smi_state_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/smi_edge_sampler.sv
module smi_edge_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mgmt_clk_i,
  input  logic mgmt_data_i,
  output logic rise_o,
  output logic fall_o,
  output logic bit_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clk_sync_q;
  logic [SYNC_STAGES-1:0] dat_sync_q;
  logic                   clk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sync_q <= '0;
      dat_sync_q <= '1;
      clk_prev_q <= 1'b0;
    end else begin
      clk_sync_q <= {clk_sync_q[MSB-1:0], mgmt_clk_i};
      dat_sync_q <= {dat_sync_q[MSB-1:0], mgmt_data_i};
      clk_prev_q <= clk_sync_q[MSB];
    end
  end

  assign rise_o = clk_sync_q[MSB] & ~clk_prev_q;
  assign fall_o = ~clk_sync_q[MSB] & clk_prev_q;
  assign bit_o  = dat_sync_q[MSB];
endmodule

// File: rtl/smi_frame_fsm.sv
module smi_frame_fsm
  import smi_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5,
  parameter int PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              bit_i,
  input  logic [ADDR_W-1:0] local_id_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              data_o,
  output logic              oe_o
);
  localparam int CNT_MAX = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PRE_CNT  = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_W - 1);

  smi_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] dev_q, reg_q;
  logic              dev_hit_q;
  logic [DATA_W-1:0] sh_q, wr_data_q;
  logic              wr_stb_q, oe_q, data_q;
  logic              rd_hit;

  assign rd_hit = dev_hit_q && (op_q == OP_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_PRE;
      cnt_q     <= '0;
      op_q      <= '0;
      dev_q     <= '0;
      reg_q     <= '0;
      dev_hit_q <= 1'b0;
      sh_q      <= '0;
      wr_data_q <= '0;
      wr_stb_q  <= 1'b0;
    end else begin
      wr_stb_q <= 1'b0;
      if (rise_i) begin
        unique case (state_q)
          S_PRE: begin
            if (bit_i) begin
              if (cnt_q < PRE_CNT) cnt_q <= cnt_q + 1'b1;
            end else begin
              if (cnt_q == PRE_CNT) state_q <= S_ST1;
              cnt_q <= '0;
            end
          end
          S_ST1: begin
            state_q <= bit_i ? S_OP : S_PRE;
            cnt_q   <= '0;
          end
          S_OP: begin
            op_q <= {op_q[0], bit_i};
            if (cnt_q == 1) begin
              cnt_q   <= '0;
              state_q <= ({op_q[0], bit_i} == OP_RD || {op_q[0], bit_i} == OP_WR)
                         ? S_DEV : S_PRE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_DEV: begin
            dev_q <= {dev_q[ADDR_W-2:0], bit_i};
            if (cnt_q == ADDR_END) begin
              dev_hit_q <= ({dev_q[ADDR_W-2:0], bit_i} == local_id_i);
              cnt_q     <= '0;
              state_q   <= S_REG;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_REG: begin
            reg_q <= {reg_q[ADDR_W-2:0], bit_i};
            if (cnt_q == ADDR_END) begin
              cnt_q   <= '0;
              state_q <= S_TA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_TA: begin
            // register address is complete here: capture read word
            if (cnt_q == 0) begin
              sh_q  <= rd_data_i;
              cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q   <= '0;
              state_q <= S_DATA;
            end
          end
          S_DATA: begin
            sh_q <= {sh_q[DATA_W-2:0], bit_i};
            if (cnt_q == DATA_END) begin
              cnt_q     <= '0;
              state_q   <= S_PRE;
              wr_data_q <= {sh_q[DATA_W-2:0], bit_i};
              wr_stb_q  <= dev_hit_q && (op_q == OP_WR);
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            state_q <= S_PRE;
            cnt_q   <= '0;
          end
        endcase
      end
    end
  end

  // drive updates on falling edges so the line settles before the next rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      data_q <= 1'b0;
    end else if (fall_i) begin
      oe_q   <= rd_hit && ((state_q == S_TA && cnt_q == 1) || state_q == S_DATA);
      data_q <= (state_q == S_DATA) ? sh_q[DATA_W-1] : 1'b0;
    end
  end

  assign reg_addr_o = reg_q;
  assign wr_stb_o   = wr_stb_q;
  assign wr_data_o  = wr_data_q;
  assign data_o     = data_q;
  assign oe_o       = oe_q;

  a_r2_start_after_preamble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ST1 && $past(state_q) == S_PRE) |-> $past(cnt_q) == PRE_CNT);
  a_r3_bad_start_hunts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && state_q == S_ST1 && !bit_i) |=> state_q == S_PRE);
  a_r6_drive_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (dev_hit_q && op_q == OP_RD));
  a_r4_release_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && state_q == S_PRE) |=> !oe_q);
  a_r5_store_at_frame_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_q |-> (state_q == S_PRE && cnt_q == 0));
endmodule

// File: rtl/smi_page_bank.sv
module smi_page_bank #(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 5,
  parameter int PAGES         = 4,
  parameter int PAGE_REG_ADDR = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int PAGE_W  = $clog2(PAGES);
  localparam int ENTRIES = PAGES * (2 ** ADDR_W);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(PAGE_REG_ADDR);

  logic [DATA_W-1:0] mem_q [ENTRIES];
  logic [PAGE_W-1:0] page_q;
  logic              sel_hit;

  assign sel_hit = (addr_i == SEL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (wr_stb_i) begin
      if (sel_hit) page_q <= wr_data_i[PAGE_W-1:0];
      else         mem_q[{page_q, addr_i}] <= wr_data_i;
    end
  end

  assign rd_data_o = sel_hit ? DATA_W'(page_q) : mem_q[{page_q, addr_i}];

  a_r7_page_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_i && sel_hit) |=> $stable(page_q));
  a_r8_page_write_only_selector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !sel_hit) |=> $stable(page_q));
endmodule

// File: rtl/smi_paged_regfile.sv
module smi_paged_regfile #(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 5,
  parameter int PAGES         = 4,
  parameter int PAGE_REG_ADDR = 31,
  parameter int PRE_LEN       = 32,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] local_id_i,
  input  logic              mgmt_clk_i,
  input  logic              mgmt_data_i,
  output logic              mgmt_data_o,
  output logic              mgmt_data_oe_o
);
  logic              rise, fall, sbit, wr_stb;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  smi_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mgmt_clk_i  (mgmt_clk_i),
    .mgmt_data_i (mgmt_data_i),
    .rise_o      (rise),
    .fall_o      (fall),
    .bit_o       (sbit)
  );

  smi_frame_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_LEN(PRE_LEN)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .fall_i     (fall),
    .bit_i      (sbit),
    .local_id_i (local_id_i),
    .rd_data_i  (rd_data),
    .reg_addr_o (reg_addr),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .data_o     (mgmt_data_o),
    .oe_o       (mgmt_data_oe_o)
  );

  smi_page_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGES(PAGES), .PAGE_REG_ADDR(PAGE_REG_ADDR)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stb_i  (wr_stb),
    .addr_i    (reg_addr),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data)
  );

  a_r1_quiet_out_of_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mgmt_data_oe_o) |-> $past(fall));
endmodule

// File: tb/smi_paged_regfile_bench.sv
module smi_paged_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk = 1'b0;
  logic tb_drv = 1'b1;
  logic tb_val = 1'b1;
  logic dout, doe, line;
  logic [4:0] my_id = 5'h13;

  always #4 clk = ~clk;

  assign line = tb_drv ? tb_val : (doe ? dout : 1'b1);

  smi_paged_regfile u_smi_paged_regfile (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .local_id_i     (my_id),
    .mgmt_clk_i     (mclk),
    .mgmt_data_i    (line),
    .mgmt_data_o    (dout),
    .mgmt_data_oe_o (doe)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] m_mem [128];
  logic [1:0]  m_page;
  bit          g_any_oe, g_ta0_oe, g_ta1_oe, g_ta1_out, g_data_oe;
  logic [15:0] g_word;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rd(input logic [4:0] ra);
    return (ra == 5'd31) ? {14'b0, m_page} : m_mem[{m_page, ra}];
  endfunction

  task automatic model_wr(input logic [4:0] ra, input logic [15:0] wd);
    if (ra == 5'd31) m_page = wd[1:0];
    else m_mem[{m_page, ra}] = wd;
  endtask

  task automatic put_bit(input bit drv, input bit val, output bit s_oe, output bit s_out);
    mclk = 1'b0;
    tb_drv = drv;
    tb_val = val;
    repeat (8) @(negedge clk);
    s_oe = doe;
    s_out = dout;
    mclk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                           input logic [4:0] dev, input logic [4:0] ra, input logic [15:0] wd);
    bit o, d;
    logic [13:0] hdr;
    g_any_oe = 0; g_ta0_oe = 0; g_ta1_oe = 0; g_ta1_out = 1; g_data_oe = 1; g_word = '0;
    hdr = {st, op, dev, ra};
    for (int i = 0; i < pre; i++) begin put_bit(1, 1, o, d); g_any_oe |= o; end
    for (int i = 13; i >= 0; i--) begin put_bit(1, hdr[i], o, d); g_any_oe |= o; end
    if (op == 2'b10) begin
      put_bit(0, 0, o, d); g_ta0_oe = o; g_any_oe |= o;
      put_bit(0, 0, o, d); g_ta1_oe = o; g_ta1_out = d; g_any_oe |= o;
      for (int i = 15; i >= 0; i--) begin
        put_bit(0, 0, o, d); g_word[i] = d; g_data_oe &= o; g_any_oe |= o;
      end
    end else begin
      put_bit(1, 1, o, d); g_any_oe |= o;
      put_bit(1, 0, o, d); g_any_oe |= o;
      for (int i = 15; i >= 0; i--) begin put_bit(1, wd[i], o, d); g_any_oe |= o; end
    end
    tb_drv = 1'b1;
    tb_val = 1'b1;
  endtask

  task automatic idle_check(input string rq);
    bit o, d;
    put_bit(0, 0, o, d);
    chk(!o, rq, "line released after frame", o, 0);
    tb_drv = 1'b1;
  endtask

  task automatic do_write(input logic [4:0] ra, input logic [15:0] wd, input string rq);
    run_frame(32, 2'b01, 2'b01, my_id, ra, wd);
    chk(!g_any_oe, rq, "write frame drove line", g_any_oe, 0);
    model_wr(ra, wd);
  endtask

  task automatic do_read(input logic [4:0] ra, input string rq);
    logic [15:0] e;
    e = model_rd(ra);
    run_frame(32, 2'b01, 2'b10, my_id, ra, 16'h0);
    chk(!g_ta0_oe, "R4", "turnaround bit 1 driven", g_ta0_oe, 0);
    chk(g_ta1_oe && !g_ta1_out, "R4", "turnaround bit 2 not driven 0",
        {g_ta1_oe, g_ta1_out}, 2'b10);
    chk(g_data_oe, "R4", "data bits not all driven", g_data_oe, 1);
    chk(g_word == e, rq, $sformatf("read addr %0d page %0d", ra, m_page), g_word, e);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) m_mem[i] = '0;
    m_page = '0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk(!doe, "R1", "oe during reset", doe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!doe, "R1", "oe after reset", doe, 0);

    // R1 reset contents, R7/R8 default page
    do_read(5'd0, "R1");
    do_read(5'd31, "R1");
    idle_check("R4");

    // R5 write then read back
    do_write(5'd4, 16'hA5A5, "R5");
    idle_check("R4");
    do_read(5'd4, "R5");
    idle_check("R4");

    // R7 page switch, R8 page independence
    do_write(5'd31, 16'hFFFF, "R7");
    do_read(5'd31, "R7");
    do_read(5'd4, "R8");
    do_write(5'd4, 16'h1234, "R8");
    do_write(5'd31, 16'hFFFC, "R7");
    do_read(5'd31, "R7");
    do_read(5'd4, "R8");

    // R2 short preamble: ignored
    run_frame(31, 2'b01, 2'b01, my_id, 5'd4, 16'h0F00);
    chk(!g_any_oe, "R2", "short preamble write drove line", g_any_oe, 0);
    idle_check("R2");
    do_read(5'd4, "R2");
    run_frame(31, 2'b01, 2'b10, my_id, 5'd4, 16'h0);
    chk(!g_any_oe, "R2", "short preamble read drove line", g_any_oe, 0);
    idle_check("R2");

    // R3 bad start and bad opcodes
    run_frame(32, 2'b00, 2'b01, my_id, 5'd4, 16'h1234);
    run_frame(32, 2'b01, 2'b11, my_id, 5'd4, 16'h1234);
    run_frame(32, 2'b01, 2'b00, my_id, 5'd4, 16'h1234);
    idle_check("R3");
    do_read(5'd4, "R3");
    run_frame(32, 2'b00, 2'b10, my_id, 5'd4, 16'h0);
    chk(!g_any_oe, "R3", "bad start read drove line", g_any_oe, 0);

    // R6 foreign device address
    run_frame(32, 2'b01, 2'b01, my_id ^ 5'h01, 5'd4, 16'h7777);
    chk(!g_any_oe, "R6", "foreign write drove line", g_any_oe, 0);
    run_frame(32, 2'b01, 2'b10, my_id ^ 5'h10, 5'd4, 16'h0);
    chk(!g_any_oe, "R6", "foreign read drove line", g_any_oe, 0);
    do_read(5'd4, "R6");

    // R9 back-to-back frames, exactly 32 ones, no idle
    do_write(5'd7, 16'h0F0F, "R9");
    do_read(5'd7, "R9");
    do_write(5'd31, 16'h0001, "R9");
    do_read(5'd7, "R9");
    idle_check("R9");

    // seeded random mix
    for (int n = 0; n < 40; n++) begin
      int kind;
      logic [4:0]  ra;
      logic [15:0] wd;
      kind = $urandom % 8;
      ra   = 5'($urandom);
      wd   = 16'($urandom);
      if (kind == 0) do_write(5'd31, wd, "R7");
      else if (kind <= 3) do_write(ra, wd, "R5");
      else if (kind <= 6) do_read(ra, "R8");
      else begin
        run_frame(32, 2'b01, ((wd[0]) ? 2'b10 : 2'b01), my_id ^ (5'($urandom % 31) + 5'd1),
                  ra, wd);
        chk(!g_any_oe, "R6", "random foreign frame drove line", g_any_oe, 0);
      end
      if (wd[3]) idle_check("R4");
    end
    for (int r = 0; r < 32; r += 9) do_read(5'(r), "R8");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule